// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block writes a block of bytes into an electrically programmable read-only memory. It starts at address zero with the high programming supply requested. For each byte it drives the address and data, asserts chip enable, and fires a fixed-width program strobe. It then reads the byte back and moves on if the read matches. If the read does not match, it fires another strobe. A per-byte attempt counter stops this: once the limit is used up and the byte still reads wrong, the device fails. After the last byte, the sequencer drops the supply request to normal level and reads every byte again, comparing each one against the source. It ends with a done flag and a pass/fail result.

Source bytes come from a local buffer through an address/data port with a combinational read. All timing is given as clock-cycle counts: setup before the strobe, strobe width, data hold after the strobe, and read sampling delay. Voltage generation is outside the block, so the supply appears only as the `prog_supply_req` output.

States: `S_IDLE` (after reset), `S_SETUP` (address, data, enables and supply settle), `S_PULSE` (strobe low), `S_HOLD` (data held after the strobe), `S_VERIFY` (read back at programming supply), `S_FSETUP` (supply dropped, settle), `S_FREAD` (final compare, one byte per sampling window), `S_DONE` (result held). Transitions:
- start: `S_IDLE`/`S_DONE` to `S_SETUP`.
- timer expiry: `S_SETUP` to `S_PULSE`, `S_PULSE` to `S_HOLD`, `S_HOLD` to `S_VERIFY`, `S_FSETUP` to `S_FREAD`.
- verify pass: `S_VERIFY` to `S_SETUP` at the next address, or to `S_FSETUP` after the last address.
- verify retry: `S_VERIFY` to `S_SETUP` at the same address.
- verify exhausted: `S_VERIFY` to `S_DONE` with fail.
- final step: `S_FREAD` to itself at the next address.
- final end: `S_FREAD` to `S_DONE`, passing only if every byte matched.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done and pass are 0, chip enable, output enable and strobe (all active low) are 1, the supply request is 0, and the data driver is off.
- R2: A start pulse in idle moves the block to setup in the next cycle: busy 1, supply request 1, chip enable low, output enable high, address 0, data equal to source byte 0 and driven.
- R3: Every strobe lasts exactly CYC_PULSE cycles and occurs only while chip enable is low, output enable is high, the supply request is 1 and data are driven.
- R4: Address, data, driver enable, output enable, chip enable and supply request stay unchanged for at least CYC_SETUP cycles before the strobe falls and for at least CYC_HOLD cycles after it rises.
- R5: Output enable goes low only in verify and final compare, and the data driver is never on while output enable is low.
- R6: Read data are compared only after output enable has been low, with the address unchanged, for CYC_SAMPLE cycles.
- R7: A verify match moves to the next address with the attempt count cleared. A mismatch fires another strobe at the same address.
- R8: When a byte still mismatches after MAX_TRIES strobes, the block ends with done 1 and pass 0 and fires no further strobe.
- R9: After the last address verifies, the supply request drops to 0 and, after CYC_SETUP cycles, every byte is read and compared. The run passes (pass 1) only if all bytes match, otherwise it fails at the first mismatch.
- R10: Done and pass stay stable until the next start, busy is 0 while done is 1, and a start during a run has no effect.
- R11: A start while done begins a new run from address 0 with pass cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run from idle or done |
| buf_addr | output | ADDR_W | Source buffer read address |
| buf_data | input | DATA_W | Source byte at buf_addr |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data read from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| prog_supply_req | output | 1 | Request for programming-level supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Result of the finished run |

## Verification
Two outcomes are hard to reach from the ports. One is a byte that needs exactly the attempt limit. The other is a byte that reads back correctly at programming supply but wrong at normal supply. Either depends on how the memory cells behave, not on anything the sequencer drives. The bench therefore uses a memory model in which each address needs a chosen number of strobes before it takes its data, and in which one address can be marked as weak so that it flips a bit only while the supply request is low. The vector table sets these per run, including demands at, under and over the limit. The model returns garbage data until the sampling window has elapsed, so an early compare shows up as a wrong result.

// File: rtl/eps_pkg.sv
package eps_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VERIFY,
        S_FSETUP,
        S_FREAD,
        S_DONE
    } eps_state_e;

endpackage

// File: rtl/eps_phase_timer.sv
module eps_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // the current phase has lasted len cycles once cnt reaches len-1
    assign expired = (cnt_q == len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/eps_try_counter.sv
module eps_try_counter #(
    parameter int MAX_TRIES = 25,
    parameter int TRY_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [TRY_W-1:0] tries,
    output logic             at_limit
);
    assign at_limit = (tries >= TRY_W'(MAX_TRIES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tries <= '0;
        else if (clear)
            tries <= '0;
        else if (bump && !at_limit)
            tries <= tries + TRY_W'(1);
    end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eps_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int MAX_TRIES  = 25,
    parameter int CYC_SETUP  = 200,
    parameter int CYC_PULSE  = 10000,
    parameter int CYC_HOLD   = 200,
    parameter int CYC_SAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              prog_supply_req,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    localparam int MAX_AB  = (CYC_SETUP > CYC_HOLD) ? CYC_SETUP : CYC_HOLD;
    localparam int MAX_CD  = (CYC_PULSE > CYC_SAMPLE) ? CYC_PULSE : CYC_SAMPLE;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int TRY_W   = $clog2(MAX_TRIES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    eps_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              pass_q;
    logic [CNT_W-1:0]  phase_len;
    logic              expired, restart, match, last;
    logic              launch, vfy_ok, fread_step, fread_win;
    logic [TRY_W-1:0]  tries;
    logic              at_limit;

    assign match  = (mem_dq_in == buf_data);
    assign last   = (addr_q == LAST_ADDR);
    assign launch = start && (state_q == S_IDLE || state_q == S_DONE);
    assign vfy_ok = (state_q == S_VERIFY) && expired && match;
    assign fread_step = (state_q == S_FREAD) && expired && match && !last;
    assign fread_win  = (state_q == S_FREAD) && expired && match && last;
    assign restart    = (state_d != state_q) || fread_step;

    always_comb begin
        unique case (state_q)
            S_SETUP, S_FSETUP: phase_len = CNT_W'(CYC_SETUP);
            S_PULSE:           phase_len = CNT_W'(CYC_PULSE);
            S_HOLD:            phase_len = CNT_W'(CYC_HOLD);
            S_VERIFY, S_FREAD: phase_len = CNT_W'(CYC_SAMPLE);
            default:           phase_len = CNT_W'(1);
        endcase
    end

    eps_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .len(phase_len), .expired(expired)
    );

    eps_try_counter #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) tries_i (
        .clk(clk), .rst_n(rst_n),
        .clear(launch || vfy_ok),
        .bump((state_q == S_PULSE) && expired),
        .tries(tries), .at_limit(at_limit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: if (start)   state_d = S_SETUP;
            S_SETUP:        if (expired) state_d = S_PULSE;
            S_PULSE:        if (expired) state_d = S_HOLD;
            S_HOLD:         if (expired) state_d = S_VERIFY;
            S_VERIFY: if (expired) begin
                if (match)         state_d = last ? S_FSETUP : S_SETUP;
                else if (at_limit) state_d = S_DONE;
                else               state_d = S_SETUP;
            end
            S_FSETUP:       if (expired) state_d = S_FREAD;
            S_FREAD: if (expired && (!match || last)) state_d = S_DONE;
            default:        state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // address and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pass_q <= 1'b0;
        end else begin
            if (launch) begin
                addr_q <= '0;
                pass_q <= 1'b0;
            end else if (vfy_ok || fread_step) begin
                addr_q <= addr_q + ADDR_W'(1);
            end
            if (fread_win) pass_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        buf_addr        = addr_q;
        mem_addr        = addr_q;
        mem_dq_out      = buf_data;
        mem_dq_oe       = 1'b0;
        mem_ce_n        = 1'b1;
        mem_oe_n        = 1'b1;
        mem_pgm_n       = 1'b1;
        prog_supply_req = 1'b0;
        busy            = 1'b1;
        done            = 1'b0;
        pass            = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_SETUP, S_HOLD: begin
                mem_ce_n = 1'b0; mem_dq_oe = 1'b1; prog_supply_req = 1'b1;
            end
            S_PULSE: begin
                mem_ce_n = 1'b0; mem_dq_oe = 1'b1; prog_supply_req = 1'b1;
                mem_pgm_n = 1'b0;
            end
            S_VERIFY: begin
                mem_ce_n = 1'b0; mem_oe_n = 1'b0; prog_supply_req = 1'b1;
            end
            S_FSETUP: mem_ce_n = 1'b0;
            S_FREAD: begin
                mem_ce_n = 1'b0; mem_oe_n = 1'b0;
            end
            default: begin
                busy = 1'b0; done = 1'b1; pass = pass_q;
            end
        endcase
    end
endmodule

// File: rtl/eps_prog_seq_chk.sv
module eps_prog_seq_chk #(
    parameter int ADDR_W    = 4,
    parameter int MAX_TRIES = 25,
    parameter int CYC_PULSE = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_pgm_n,
    input logic              prog_supply_req,
    input logic              busy,
    input logic              done,
    input logic              pass
);
    localparam int PW_W = $clog2(CYC_PULSE + 2);
    localparam int TC_W = $clog2(MAX_TRIES + 2);

    logic [PW_W-1:0]   pw_cnt;
    logic [TC_W-1:0]   try_cnt;
    logic [ADDR_W-1:0] addr_seen;
    logic              pgm_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_cnt <= '0; try_cnt <= '0; addr_seen <= '0; pgm_prev <= 1'b1;
        end else begin
            pw_cnt    <= mem_pgm_n ? '0 : pw_cnt + PW_W'(1);
            addr_seen <= mem_addr;
            pgm_prev  <= mem_pgm_n;
            if (!busy || mem_addr != addr_seen) try_cnt <= '0;
            else if (pgm_prev && !mem_pgm_n)    try_cnt <= try_cnt + TC_W'(1);
        end
    end

    // R3
    strobe_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && prog_supply_req && mem_dq_oe));

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pgm_n) |-> (pw_cnt == PW_W'(CYC_PULSE)));

    // R5
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R8
    tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        try_cnt <= TC_W'(MAX_TRIES));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind eprom_prog_seq eps_prog_seq_chk #(
    .ADDR_W(ADDR_W), .MAX_TRIES(MAX_TRIES), .CYC_PULSE(CYC_PULSE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .prog_supply_req(prog_supply_req),
    .busy(busy), .done(done), .pass(pass)
);

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
    localparam int ADDR_W = 2, DATA_W = 8, MAX_TRIES = 4;
    localparam int CYC_SETUP = 3, CYC_PULSE = 5, CYC_HOLD = 3, CYC_SAMPLE = 4;
    localparam int NB = 1 << ADDR_W;
    localparam int NVEC = 6;
    // need0 need1 need2 need3 | weak_en | weak_addr | exp_pass | exp_pulses | seed
    localparam logic [43:0] VEC [NVEC] = '{
        44'h1111_0_0_1_04_3C,
        44'h2134_0_0_1_0A_48,
        44'h1511_0_0_0_05_54,
        44'h1111_1_2_0_04_60,
        44'h4444_0_0_1_10_6C,
        44'h1115_0_0_0_07_70
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ADDR_W-1:0] buf_addr, mem_addr;
    logic [DATA_W-1:0] buf_data, mem_dq_out, mem_dq_in;
    logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, prog_supply_req, busy, done, pass;

    always #5 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_TRIES(MAX_TRIES),
        .CYC_SETUP(CYC_SETUP), .CYC_PULSE(CYC_PULSE),
        .CYC_HOLD(CYC_HOLD), .CYC_SAMPLE(CYC_SAMPLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_addr(buf_addr),
        .buf_data(buf_data), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .prog_supply_req(prog_supply_req), .busy(busy), .done(done), .pass(pass)
    );

    // source buffer and memory model
    logic [7:0] seed = 8'h00;
    logic [7:0] mem [NB];
    int         need [NB];
    int         pcount [NB];
    logic       weak_en = 1'b0;
    logic [ADDR_W-1:0] weak_addr = '0;
    int total = 0, setup_viol = 0, hold_viol = 0, pw_viol = 0, bus_viol = 0;
    int stab = 0, hold_cnt = 0, pw = 0, rd_stab = 0;
    logic hold_act = 1'b0, pgm_prev = 1'b1;
    logic [ADDR_W-1:0] rd_last = '0;
    logic [ADDR_W+DATA_W+3:0] vec_prev = '0;
    logic [DATA_W-1:0] rd_val;

    assign buf_data = seed + DATA_W'(buf_addr);
    assign rd_val = mem[mem_addr] ^ ((weak_en && mem_addr == weak_addr && !prog_supply_req) ? 8'h01 : 8'h00);
    assign mem_dq_in = (rd_stab >= CYC_SAMPLE) ? rd_val : 8'hA5;

    always @(negedge clk) begin
        logic [ADDR_W+DATA_W+3:0] vec_now;
        vec_now = {mem_addr, mem_dq_out, mem_dq_oe, mem_oe_n, mem_ce_n, prog_supply_req};
        if (vec_now != vec_prev) begin
            if (hold_act && hold_cnt < CYC_HOLD) hold_viol++;
            hold_act = 1'b0;
            stab = 0;
        end else begin
            stab++;
            if (hold_act) hold_cnt++;
        end
        if (!mem_pgm_n && pgm_prev) begin
            if (stab < CYC_SETUP) setup_viol++;
            pw = 0;
        end
        if (!mem_pgm_n) pw++;
        if (mem_pgm_n && !pgm_prev) begin
            if (pw != CYC_PULSE) pw_viol++;
            if (!mem_ce_n && mem_oe_n && prog_supply_req && mem_dq_oe) begin
                total++;
                pcount[mem_addr]++;
                if (pcount[mem_addr] >= need[mem_addr])
                    mem[mem_addr] = mem[mem_addr] & mem_dq_out;
            end
            hold_act = 1'b1;
            hold_cnt = 1;
        end
        if (!mem_oe_n && mem_dq_oe) bus_viol++;
        if (mem_oe_n) rd_stab = 0;
        else if (mem_addr != rd_last) rd_stab = 1;
        else rd_stab++;
        rd_last  = mem_addr;
        vec_prev = vec_now;
        pgm_prev = mem_pgm_n;
    end

    int checks = 0, fails = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [43:0] v, input int idx);
        int cyc;
        @(posedge clk);
        for (int a = 0; a < NB; a++) begin
            mem[a] = 8'hFF;
            pcount[a] = 0;
            need[a] = int'(v[43 - 4*a -: 4]);
        end
        weak_en = v[24];
        weak_addr = v[21:20];
        seed = v[7:0];
        total = 0; setup_viol = 0; hold_viol = 0; pw_viol = 0; bus_viol = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2: first cycle of setup
        chk(busy && prog_supply_req && !mem_ce_n && mem_oe_n && mem_pgm_n &&
            mem_dq_oe && mem_addr == 0 && mem_dq_out == v[7:0], "R2 launch",
            {mem_addr, mem_dq_out}, {2'b00, v[7:0]});
        repeat (20) @(negedge clk);
        // R10: start while busy must be ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(done, "R10 run ends", int'(done), 1);
        // R8 R9: result
        chk(pass == v[16], "R8/R9 pass result", int'(pass), int'(v[16]));
        // R7 R8: strobe count
        chk(total == int'(v[15:8]), "R7/R8 strobe count", total, int'(v[15:8]));
        chk(pw_viol == 0, "R3 strobe width", pw_viol, 0);
        chk(setup_viol == 0 && hold_viol == 0, "R4 setup/hold", setup_viol + hold_viol, 0);
        chk(bus_viol == 0, "R5 bus exclusive", bus_viol, 0);
        if (v[16] && !v[24]) begin
            for (int a = 0; a < NB; a++)
                chk(mem[a] == v[7:0] + 8'(a), "R6/R7 memory content", mem[a], v[7:0] + 8'(a));
        end
        repeat (15) @(negedge clk);
        chk(done && !busy && pass == v[16] && mem_ce_n && !prog_supply_req && mem_pgm_n,
            "R10 result held", {done, busy, pass}, {1'b1, 1'b0, v[16]});
        $display("vector %0d: strobes=%0d pass=%0b", idx, total, pass);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !pass && mem_ce_n && mem_oe_n && mem_pgm_n &&
            !prog_supply_req && !mem_dq_oe, "R1 reset state",
            {busy, done, pass, mem_ce_n, mem_oe_n, mem_pgm_n, prog_supply_req, mem_dq_oe},
            8'b00011100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R1 idle after release", {busy, done}, 0);
        // vector table; each run after the first starts from done (R11)
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);
        // R11: restart after a failed run gives a clean pass
        run_vec(VEC[0], NVEC);
        // R1: reset in the middle of a run
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && mem_pgm_n && mem_ce_n && !prog_supply_req && !mem_dq_oe,
            "R1 reset mid-run", {busy, done, mem_pgm_n, mem_ce_n}, 4'b0011);
        rst_n = 1'b1;
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule